// File: doc/BRIEF.md
# Reflected CRC-32 Frame Checksum Engine

This block computes the 32-bit frame check sequence used on Ethernet links, one byte per enabled clock. Inside it is a plain, non-reflected parallel CRC core that shifts each byte in most significant bit first. Around that core sits an adapter layer. It mirrors the bit order of every incoming byte, so the least significant bit of each byte reaches the shift register first, as the line protocol requires. It also mirrors the 32-bit core state and complements it to form the checksum ready for transmission.

The core's next-state logic is built at elaboration time. A constant function runs eight steps of a bit-serial shift register with the generator polynomial. From those steps it extracts, for every state bit, which current-state bits and which data bits feed it. Each next-state bit is then a pure XOR of the selected bits, with no lookup table. A sender pulses `restart` at the start of a frame, presents the frame bytes with `byte_vld`, and reads `fcs_out`. A receiver feeds the frame followed by its received checksum, least significant byte first, and compares `crc_state` against the fixed residue.

Top module: `eth_crc32_refl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `crc_state` becomes 0xFFFFFFFF on that edge. As a result, `fcs_out` reads 0x00000000.
- R2: When `restart` is high at an edge with `rst_n` high, `crc_state` becomes 0xFFFFFFFF. The byte on `byte_in` is ignored, even if `byte_vld` is also high.
- R3: At each edge where `byte_vld` is high, `restart` is low and `rst_n` is high, exactly one byte is folded in. The new `crc_state` equals eight steps of a serial shift register with polynomial 0x04C11DB7 (x^32 implicit), MSB first. Each step shifts the register left by one and XORs in the polynomial when old bit 31 XOR the data bit is 1. The data bits are taken in the order `byte_in[0]`, `byte_in[1]`, … `byte_in[7]`.
- R4: At an edge where `byte_vld` and `restart` are low and `rst_n` is high, `crc_state` keeps its value, whatever `byte_in` carries.
- R5: `fcs_out` is combinational from `crc_state`: `fcs_out[i]` = NOT `crc_state[31-i]` for every i.
- R6: After a restart and the nine ASCII bytes "123456789" (0x31 to 0x39), `fcs_out` is 0xCBF43926.
- R7: After a restart, a frame of any length followed by that frame's `fcs_out` sent least significant byte first leaves `crc_state` at 0xC704DD7B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset, loads the initial state |
| restart | input | 1 | Synchronous frame start, reloads the initial state |
| byte_vld | input | 1 | Fold `byte_in` into the state on this edge |
| byte_in | input | 8 | Data byte, bit 0 is first on the line |
| crc_state | output | 32 | Raw running state of the non-reflected core |
| fcs_out | output | 32 | Mirrored and complemented state, ready to transmit |

## Verification
The bench targets the bit-order conventions, where a wrong design usually still produces plausible-looking numbers. If a core skips the input mirroring, or mirrors the wrong way, it drifts from the serial model on the first asymmetric byte and misses 0xCBF43926. If the output stage omits the complement or the mirror, it gives the wrong checksum and a wrong receive residue. The bench also drives `restart` together with `byte_vld`, and lets `byte_in` change while idle. A design that gave the byte priority would not return to 0xFFFFFFFF, and a design that folded while idle would move the state. Resets in the middle of a frame and back-to-back frames of random length check that no stale state survives.

// File: rtl/crc32_refl_pkg.sv
// Package: shared widths, polynomial constants and the elaboration-time
// helpers that derive the parallel next-state equations.
// Assumes: MSB-first, non-reflected serial shift register convention.
package crc32_refl_pkg;

    localparam int CRC_W  = 32;
    localparam int DATA_W = 8;

    typedef logic [CRC_W-1:0]  crc_word_t;
    typedef logic [DATA_W-1:0] data_word_t;

    localparam crc_word_t GEN_POLY  = 32'h04C1_1DB7;
    localparam crc_word_t SEED      = 32'hFFFF_FFFF;
    localparam crc_word_t OUT_XOR   = 32'hFFFF_FFFF;

    // Advance a serial register DATA_W steps, data MSB first.
    function automatic crc_word_t serial_fold(input crc_word_t st,
                                              input data_word_t dat,
                                              input crc_word_t poly);
        crc_word_t s;
        logic      fb;
        s = st;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = s[CRC_W-1] ^ dat[i];
            s  = s << 1;
            if (fb) s = s ^ poly;
        end
        return s;
    endfunction

    // Which current-state bits feed next-state bit k (linearity: unit vectors).
    function automatic crc_word_t state_taps(input int k, input crc_word_t poly);
        crc_word_t m;
        crc_word_t r;
        m = '0;
        for (int j = 0; j < CRC_W; j++) begin
            r    = serial_fold(crc_word_t'(1) << j, '0, poly);
            m[j] = r[k];
        end
        return m;
    endfunction

    // Which data bits feed next-state bit k.
    function automatic data_word_t data_taps(input int k, input crc_word_t poly);
        data_word_t m;
        crc_word_t  r;
        m = '0;
        for (int j = 0; j < DATA_W; j++) begin
            r    = serial_fold('0, data_word_t'(1) << j, poly);
            m[j] = r[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/crc_bit_mirror.sv
// Module: crc_bit_mirror
// Reverses the bit order of a word of parameter width. Pure wiring.
// Assumes: nothing; used for both the byte input and the 32-bit output.
module crc_bit_mirror #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // One wire per bit position, swapped end for end.
    for (genvar i = 0; i < W; i++) begin : g_swap
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/crc_xor_core.sv
// Module: crc_xor_core
// Parallel next-state logic of a non-reflected, MSB-first CRC that folds
// one DATA_W-bit word. Each output bit is an XOR of tap-selected state and
// data bits; the taps are derived at elaboration from eight serial steps.
// Assumes: data already in MSB-first order.
module crc_xor_core
    import crc32_refl_pkg::*;
#(
    parameter crc_word_t POLY = GEN_POLY
) (
    input  crc_word_t  cur,
    input  data_word_t dat,
    output crc_word_t  nxt
);

    // Per-bit XOR tree with constant tap masks.
    for (genvar k = 0; k < CRC_W; k++) begin : g_bit
        localparam crc_word_t  S_TAPS = state_taps(k, POLY);
        localparam data_word_t D_TAPS = data_taps(k, POLY);
        assign nxt[k] = (^(cur & S_TAPS)) ^ (^(dat & D_TAPS));
    end

endmodule

// File: rtl/crc_state_reg.sv
// Module: crc_state_reg
// Holds the running CRC state. Reset and restart both load the seed;
// restart wins over a valid byte. Otherwise it loads nxt when enabled.
// Assumes: synchronous active-low reset.
module crc_state_reg
    import crc32_refl_pkg::*;
#(
    parameter crc_word_t INIT = SEED
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  logic      load,
    input  crc_word_t nxt,
    output crc_word_t q
);

    // State update: seed on reset/restart, fold on load, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= INIT;
        else if (restart) q <= INIT;
        else if (load)    q <= nxt;
    end

endmodule

// File: rtl/eth_crc32_refl.sv
// Module: eth_crc32_refl (top)
// Reflected CRC-32 engine: mirrors each byte into a non-reflected core,
// and mirrors plus complements the core state to form the checksum.
// Assumes: one byte per enabled clock; bit 0 of each byte is first on line.
module eth_crc32_refl
    import crc32_refl_pkg::*;
#(
    parameter crc_word_t POLY      = GEN_POLY,
    parameter crc_word_t INIT      = SEED,
    parameter crc_word_t FINAL_XOR = OUT_XOR
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        byte_vld,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_state,
    output logic [31:0] fcs_out
);

    data_word_t byte_msb_first;
    crc_word_t  state_q;
    crc_word_t  state_nxt;
    crc_word_t  state_mirrored;

    // Input adapter: line order (LSB first) to core order (MSB first).
    crc_bit_mirror #(.W(DATA_W)) u_in_mirror (
        .din  (byte_in),
        .dout (byte_msb_first)
    );

    // Parallel fold of one byte.
    crc_xor_core #(.POLY(POLY)) u_core (
        .cur (state_q),
        .dat (byte_msb_first),
        .nxt (state_nxt)
    );

    // Running state.
    crc_state_reg #(.INIT(INIT)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .load    (byte_vld),
        .nxt     (state_nxt),
        .q       (state_q)
    );

    // Output adapter: mirror the state, then complement.
    crc_bit_mirror #(.W(CRC_W)) u_out_mirror (
        .din  (state_q),
        .dout (state_mirrored)
    );

    assign crc_state = state_q;
    assign fcs_out   = state_mirrored ^ FINAL_XOR;

endmodule

// File: rtl/eth_crc32_refl_chk.sv
// Module: eth_crc32_refl_chk
// Assertion checker bound to eth_crc32_refl. Uses its own serial model of
// the reflected fold to check each enabled cycle.
module eth_crc32_refl_chk #(
    parameter logic [31:0] POLY = 32'h04C1_1DB7,
    parameter logic [31:0] INIT = 32'hFFFF_FFFF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        restart,
    input logic        byte_vld,
    input logic [7:0]  byte_in,
    input logic [31:0] crc_state,
    input logic [31:0] fcs_out
);

    // Line-order serial step: byte bit 0 first.
    function automatic logic [31:0] line_fold(input logic [31:0] s0, input logic [7:0] b);
        logic [31:0] s;
        s = s0;
        for (int i = 0; i < 8; i++) begin
            if (s[31] ^ b[i]) s = {s[30:0], 1'b0} ^ POLY;
            else              s = {s[30:0], 1'b0};
        end
        return s;
    endfunction

    function automatic logic [31:0] flip32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    logic rst_low_q = 1'b0;

    // Remember that the previous edge saw reset, and check its effect.
    always_ff @(posedge clk) begin
        rst_low_q <= !rst_n;
        if (rst_low_q)
            assert_reset_init_R1: assert (crc_state == INIT)
                else $error("R1: state %h after reset", crc_state);
    end

    assert_restart_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (crc_state == INIT));

    assert_fold_serial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !restart) |=> (crc_state == line_fold($past(crc_state), $past(byte_in))));

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !restart) |=> $stable(crc_state));

    assert_fcs_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_out == ~flip32(crc_state));

endmodule

bind eth_crc32_refl eth_crc32_refl_chk #(.POLY(POLY), .INIT(INIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .byte_vld  (byte_vld),
    .byte_in   (byte_in),
    .crc_state (crc_state),
    .fcs_out   (fcs_out)
);

// File: tb/test_eth_crc32_refl.sv
// Bench for eth_crc32_refl: directed corner cases plus seeded random traffic,
// compared against a serial model and an independent right-shifting model.
module test_eth_crc32_refl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [31:0] crc_state;
    logic [31:0] fcs_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_state = 32'hFFFF_FFFF;
    logic [31:0] refl_reg  = 32'hFFFF_FFFF;

    eth_crc32_refl i_eth_crc32_refl (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .crc_state (crc_state),
        .fcs_out   (fcs_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    // R3 model: serial MSB-first register fed the bit-reversed byte.
    function automatic logic [31:0] model_step(input logic [31:0] s0, input logic [7:0] b);
        logic [31:0] s;
        logic [7:0]  rb;
        s = s0;
        for (int i = 0; i < 8; i++) rb[i] = b[7-i];
        for (int i = 7; i >= 0; i--) begin
            if (s[31] ^ rb[i]) s = (s << 1) ^ 32'h04C1_1DB7;
            else               s = s << 1;
        end
        return s;
    endfunction

    // Independent reflected (right-shifting) model; checksum = ~register.
    function automatic logic [31:0] refl_step(input logic [31:0] r0, input logic [7:0] b);
        logic [31:0] r;
        r = r0 ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            if (r[0]) r = (r >> 1) ^ 32'hEDB8_8320;
            else      r = r >> 1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, update models at the edge, check mid-high.
    task automatic cycle(input logic rn, input logic st, input logic v, input logic [7:0] b,
                         input string tag);
        @(negedge clk);
        rst_n = rn; restart = st; byte_vld = v; byte_in = b;
        @(posedge clk);
        if (!rn || st) begin
            exp_state = 32'hFFFF_FFFF;
            refl_reg  = 32'hFFFF_FFFF;
        end else if (v) begin
            exp_state = model_step(exp_state, b);
            refl_reg  = refl_step(refl_reg, b);
        end
        #5;
        check(tag, crc_state, exp_state);
        check("R5", fcs_out, ~refl_reg);
    endtask

    task automatic send_byte(input logic [7:0] b);
        cycle(1'b1, 1'b0, 1'b1, b, "R3");
    endtask

    initial begin
        logic [31:0] fcs;
        logic [31:0] held;
        void'($urandom(32'h0C0F_FEE5));

        // R1: reset state
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R1");
        cycle(1'b0, 1'b0, 1'b1, 8'hA5, "R1");
        check("R1", fcs_out, 32'h0000_0000);

        // R6: check string
        cycle(1'b1, 1'b1, 1'b0, 8'h00, "R2");
        for (int i = 0; i < 9; i++) send_byte(8'h31 + 8'(i));
        check("R6", fcs_out, 32'hCBF4_3926);

        // R7: append checksum LSB first, expect residue
        fcs = fcs_out;
        for (int i = 0; i < 4; i++) send_byte(fcs[8*i +: 8]);
        check("R7", crc_state, 32'hC704_DD7B);

        // R4: idle with toggling data
        held = crc_state;
        for (int i = 0; i < 6; i++) cycle(1'b1, 1'b0, 1'b0, 8'(i * 37 + 1), "R4");
        check("R4", crc_state, held);

        // R2: restart with a valid byte present
        send_byte(8'h5A);
        cycle(1'b1, 1'b1, 1'b1, 8'hC3, "R2");
        check("R2", crc_state, 32'hFFFF_FFFF);

        // Single-byte frames at the boundary values
        cycle(1'b1, 1'b1, 1'b0, 8'h00, "R2");
        send_byte(8'h00);
        cycle(1'b1, 1'b1, 1'b0, 8'h00, "R2");
        send_byte(8'hFF);
        cycle(1'b1, 1'b1, 1'b0, 8'h00, "R2");
        send_byte(8'h01);
        send_byte(8'h80);

        // R7: random frames, each followed by its checksum
        for (int f = 0; f < 40; f++) begin
            int len;
            len = 1 + int'($urandom % 48);
            cycle(1'b1, 1'b1, 1'b0, 8'h00, "R2");
            for (int i = 0; i < len; i++) begin
                if (($urandom % 4) == 0)
                    cycle(1'b1, 1'b0, 1'b0, 8'($urandom), "R4");
                send_byte(8'($urandom));
            end
            fcs = fcs_out;
            for (int i = 0; i < 4; i++) send_byte(fcs[8*i +: 8]);
            check("R7", crc_state, 32'hC704_DD7B);
        end

        // Mixed random traffic with restarts and mid-frame resets
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 100);
            if (r < 2)       cycle(1'b0, 1'b0, 1'($urandom), 8'($urandom), "R1");
            else if (r < 7)  cycle(1'b1, 1'b1, 1'($urandom), 8'($urandom), "R2");
            else if (r < 30) cycle(1'b1, 1'b0, 1'b0, 8'($urandom), "R4");
            else             send_byte(8'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule